// File: doc/BRIEF.md
# Grouped Interrupt Combiner with Masking

The combiner takes a wide bus of level-sensitive interrupt lines and folds them into groups of eight. Every group has one output that is high while at least one of its sources is both pending and enabled. Source line n belongs to group n>>3, at bit n&7 within that group. A pending bit tracks its input level on every clock edge, before any masking is applied.

Software uses a plain 32-bit register port made of an address, a write strobe, write data and read data. Reads are registered. The register space is split into 16-byte blocks, and each block serves four consecutive groups. Each word in a block packs those four groups as byte lanes, with group 4b+k in bits [8k+7:8k]. Enables can only be changed through a set word and a clear word. Those two words read back the last value written to them, not the live mask. Two summary words above the blocks report the masked state of every group, one bit per group. An external-mode parameter makes the groups at or above a limit ignore their inputs.

Top module: `grp_irq_combiner`

## Requirements
- R1: Input line n sets bit n&7 of group n>>3. A pending bit equals the level its input had at the previous rising clock edge.
- R2: `grp_irq_o[g]` is high exactly when group g has a bit that is both pending and enabled. It changes in the cycle after the input edge or the enable write that causes the change.
- R3: A write to word 0 (address bits [3:2] = 0) of block b ORs byte k of the write data into the enable mask of group 4b+k.
- R4: A write to word 1 of block b clears every enable bit of group 4b+k whose bit in byte k of the write data is 1. The other enable bits keep their values.
- R5: Word 2 of block b reads the raw pending bytes of groups 4b..4b+3. Word 3 reads the same bytes ANDed with the enable masks.
- R6: Address 0x100 reads the masked state of groups 0..31, with group g in bit g. Address 0x104 reads groups 32..63, with group g in bit g-32. Every other address at or above 0x100 reads 0.
- R7: Word 0 and word 1 of each block read back the last data written to that address, whatever the live enable mask is.
- R8: After reset, all pending bits, enable masks, outputs and stored words are 0. The exceptions are the stored words at 0xC0, 0xC4, 0xD0 and 0xD4, which read 0x01010101.
- R9: A write to word 2 or word 3, or to any address at or above 0x100, changes no state. It raises `err_o` for exactly one cycle, in the cycle after the write.
- R10: With EXT_MODE set, groups whose index is at or above EXT_LIMIT keep their pending bits at 0, so their outputs stay low.
- R11: `rdata_o` shows the word for the address presented at a rising edge, starting from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_GROUPS*8 | Level-sensitive source lines |
| addr_i | input | ADDR_W | Byte address of the register port |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse after an illegal write |
| grp_irq_o | output | NUM_GROUPS | Per-group combined interrupt |

## Verification
The hardest case to reach from the ports is a stored set word that no longer matches the live mask. A read of word 0 must still return the old image after a clear write has removed one of the bits it set. The bench produces this by enabling a whole group and then clearing a single bit. It then reads both words and the masked status, and checks that the status reflects the cleared bit while the images do not. A second instance in external mode is fed the same bus. This shows a high-numbered group staying silent while the default instance raises the same group.

// File: rtl/comb_pkg.sv
package comb_pkg;
  localparam int SRC_PER_GRP = 8;
  localparam int GRP_PER_BLK = 4;
  localparam int WORD_W      = 32;
  localparam logic [WORD_W-1:0] IMG_PRESET = 32'h0101_0101;

  typedef enum logic [1:0] {
    W_SET = 2'd0,
    W_CLR = 2'd1,
    W_RAW = 2'd2,
    W_MSK = 2'd3
  } word_sel_e;

  // image index = block*2 + word; 0xC0,0xC4,0xD0,0xD4 map to 24..27
  function automatic bit img_preset(int idx);
    return (idx >= 24) && (idx <= 27);
  endfunction
endpackage

// File: rtl/comb_group.sv
module comb_group
  import comb_pkg::*;
#(
  parameter bit ACCEPT = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SRC_PER_GRP-1:0] src_i,
  input  logic [SRC_PER_GRP-1:0] set_i,
  input  logic [SRC_PER_GRP-1:0] clr_i,
  output logic [SRC_PER_GRP-1:0] pend_o,
  output logic [SRC_PER_GRP-1:0] en_o,
  output logic                   irq_o
);
  logic [SRC_PER_GRP-1:0] pend_q, en_q, src_gated;

  generate
    if (ACCEPT) begin : g_acc
      assign src_gated = src_i;
    end else begin : g_ign
      assign src_gated = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= src_gated;
      en_q   <= (en_q | set_i) & ~clr_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);

  generate
    if (ACCEPT) begin : g_chk
      a_r1_pend_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> pend_q == $past(src_i));
    end
  endgenerate

  a_r3_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(|set_i) |-> (en_q & $past(set_i)) == $past(set_i));

  a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(|clr_i) |-> (en_q & $past(clr_i)) == '0);

  a_r2_irq_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|pend_q) && (|en_q));
endmodule

// File: rtl/comb_regs.sv
module comb_regs
  import comb_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter int ADDR_W     = 9,
  localparam int NUM_BLOCKS = NUM_GROUPS / GRP_PER_BLK,
  localparam int BLK_W      = ADDR_W - 4,
  localparam int NUM_IMG    = NUM_BLOCKS * 2,
  localparam int NSRC       = NUM_GROUPS * SRC_PER_GRP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [NSRC-1:0]   set_o,
  output logic [NSRC-1:0]   clr_o,
  output logic [WORD_W-1:0] img_rd_o,
  output logic [BLK_W-1:0]  blk_o,
  output word_sel_e         wsel_o,
  output logic              in_range_o,
  output logic              err_o
);
  logic [BLK_W-1:0]  blk;
  word_sel_e         wsel;
  logic              in_range, legal_wr, err_q;
  logic [WORD_W-1:0] img_q [NUM_IMG];

  assign blk      = addr_i[ADDR_W-1:4];
  assign wsel     = word_sel_e'(addr_i[3:2]);
  assign in_range = int'(blk) < NUM_BLOCKS;
  assign legal_wr = wr_en_i && in_range && (wsel == W_SET || wsel == W_CLR);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
    logic hit;
    assign hit = legal_wr && (blk == BLK_W'(g / GRP_PER_BLK));
    assign set_o[g*SRC_PER_GRP +: SRC_PER_GRP] =
      (hit && wsel == W_SET) ? wdata_i[8*(g % GRP_PER_BLK) +: 8] : '0;
    assign clr_o[g*SRC_PER_GRP +: SRC_PER_GRP] =
      (hit && wsel == W_CLR) ? wdata_i[8*(g % GRP_PER_BLK) +: 8] : '0;
  end

  for (genvar i = 0; i < NUM_IMG; i++) begin : g_img
    localparam logic [WORD_W-1:0] RST_VAL = img_preset(i) ? IMG_PRESET : '0;
    logic hit;
    assign hit = legal_wr && (blk == BLK_W'(i / 2)) && (addr_i[2] == 1'(i % 2));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  img_q[i] <= RST_VAL;
      else if (hit) img_q[i] <= wdata_i;
    end
    a_r7_img_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && !$past(wr_en_i) |-> img_q[i] == $past(img_q[i]));
  end

  always_comb begin
    img_rd_o = '0;
    for (int i = 0; i < NUM_IMG; i++)
      if (in_range && {blk, addr_i[2]} == (BLK_W+1)'(i)) img_rd_o = img_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= wr_en_i && !legal_wr;
  end

  assign err_o      = err_q;
  assign blk_o      = blk;
  assign wsel_o     = wsel;
  assign in_range_o = in_range;

  a_r9_err_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && err_o |-> $past(wr_en_i));
endmodule

// File: rtl/grp_irq_combiner.sv
module grp_irq_combiner
  import comb_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter int ADDR_W     = 9,
  parameter bit EXT_MODE   = 1'b0,
  parameter int EXT_LIMIT  = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] irq_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              wr_en_i,
  input  logic [WORD_W-1:0]                 wdata_i,
  output logic [WORD_W-1:0]                 rdata_o,
  output logic                              err_o,
  output logic [NUM_GROUPS-1:0]             grp_irq_o
);
  localparam int NSRC       = NUM_GROUPS * SRC_PER_GRP;
  localparam int NUM_BLOCKS = NUM_GROUPS / GRP_PER_BLK;
  localparam int BLK_W      = ADDR_W - 4;
  localparam int SIDX_W     = ADDR_W - 2;
  localparam int SUM_WORDS  = (NUM_GROUPS + WORD_W - 1) / WORD_W;

  logic [NSRC-1:0]           set_vec, clr_vec, pend_flat, en_flat;
  logic [WORD_W-1:0]         img_rd, rd_d, rdata_q;
  logic [BLK_W-1:0]          blk;
  word_sel_e                 wsel;
  logic                      in_range;
  logic [NUM_GROUPS-1:0]     sum_vec;
  logic [SUM_WORDS*WORD_W-1:0] sum_pad;
  logic [SIDX_W-1:0]         sidx;

  comb_regs #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .set_o(set_vec), .clr_o(clr_vec), .img_rd_o(img_rd),
    .blk_o(blk), .wsel_o(wsel), .in_range_o(in_range), .err_o(err_o)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam bit ACC = !EXT_MODE || (g < EXT_LIMIT);
    comb_group #(.ACCEPT(ACC)) u_grp (
      .clk_i, .rst_ni,
      .src_i (irq_i  [g*SRC_PER_GRP +: SRC_PER_GRP]),
      .set_i (set_vec[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .clr_i (clr_vec[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .pend_o(pend_flat[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .en_o  (en_flat  [g*SRC_PER_GRP +: SRC_PER_GRP]),
      .irq_o (grp_irq_o[g])
    );
    // summary is rebuilt from the flat state, not from the group outputs
    assign sum_vec[g] = |(pend_flat[g*SRC_PER_GRP +: SRC_PER_GRP] &
                          en_flat  [g*SRC_PER_GRP +: SRC_PER_GRP]);
  end

  always_comb begin
    sum_pad = '0;
    sum_pad[NUM_GROUPS-1:0] = sum_vec;
  end

  assign sidx = addr_i[ADDR_W-1:2] - SIDX_W'(NUM_BLOCKS * GRP_PER_BLK);

  always_comb begin
    rd_d = '0;
    if (in_range) begin
      unique case (wsel)
        W_SET, W_CLR: rd_d = img_rd;
        W_RAW: begin
          for (int g = 0; g < NUM_GROUPS; g++)
            if (blk == BLK_W'(g / GRP_PER_BLK))
              rd_d[8*(g % GRP_PER_BLK) +: 8] = pend_flat[g*SRC_PER_GRP +: SRC_PER_GRP];
        end
        W_MSK: begin
          for (int g = 0; g < NUM_GROUPS; g++)
            if (blk == BLK_W'(g / GRP_PER_BLK))
              rd_d[8*(g % GRP_PER_BLK) +: 8] = pend_flat[g*SRC_PER_GRP +: SRC_PER_GRP] &
                                                en_flat  [g*SRC_PER_GRP +: SRC_PER_GRP];
        end
        default: rd_d = '0;
      endcase
    end else begin
      for (int w = 0; w < SUM_WORDS; w++)
        if (sidx == SIDX_W'(w)) rd_d = sum_pad[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_d;
  end
  assign rdata_o = rdata_q;

  a_r6_summary_matches_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_vec == grp_irq_o);

  a_r9_illegal_keeps_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && err_o |-> en_flat == $past(en_flat));
endmodule

// File: tb/grp_irq_combiner_tb.sv
`timescale 1ns/1ps
module grp_irq_combiner_tb;
  localparam int NG = 64;
  localparam int NS = NG * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq = '0;
  logic [8:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, ext_rdata;
  logic          err, ext_err;
  logic [NG-1:0] gout, ext_gout;

  always #2.5 clk = ~clk;

  grp_irq_combiner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .grp_irq_o(gout));

  grp_irq_combiner #(.EXT_MODE(1'b1), .EXT_LIMIT(16)) u_ext (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(ext_rdata), .err_o(ext_err), .grp_irq_o(ext_gout));

  int n_chk = 0, n_fail = 0;
  logic [7:0]  m_pend [NG];
  logic [7:0]  m_en   [NG];
  logic [31:0] m_img  [32];

  typedef struct { logic [31:0] exp; logic [8:0] a; string tag; } rd_item_t;
  rd_item_t rq[$];
  logic rd_issue = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] m_out();
    logic [NG-1:0] v;
    for (int g = 0; g < NG; g++) v[g] = |(m_pend[g] & m_en[g]);
    return v;
  endfunction

  function automatic logic [31:0] m_read(logic [8:0] a);
    int blk = int'(a) >> 4;
    int w   = (int'(a) >> 2) & 3;
    logic [31:0] v = '0;
    logic [NG-1:0] o = m_out();
    if (blk < 16) begin
      for (int k = 0; k < 4; k++) begin
        if (w == 2) v[8*k +: 8] = m_pend[blk*4+k];
        if (w == 3) v[8*k +: 8] = m_pend[blk*4+k] & m_en[blk*4+k];
      end
      if (w < 2) v = m_img[blk*2+w];
    end else begin
      int s = (int'(a) >> 2) - 64;
      if (s == 0) v = o[31:0];
      if (s == 1) v = o[63:32];
    end
    return v;
  endfunction

  // monitor: compares registered read data after the capturing edge
  always @(posedge clk) begin
    if (rd_issue) begin
      rd_item_t it;
      #1;
      it = rq.pop_front();
      chk($sformatf("%s rd %h", it.tag, it.a), {32'h0, rdata}, {32'h0, it.exp});
    end
  end

  task automatic rd(logic [8:0] a, string tag);
    rd_item_t it;
    @(negedge clk);
    addr = a;
    it.exp = m_read(a); it.a = a; it.tag = tag;
    rq.push_back(it);
    rd_issue = 1'b1;
    @(posedge clk); #2;
    rd_issue = 1'b0;
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d, string tag);
    int blk = int'(a) >> 4;
    int w   = (int'(a) >> 2) & 3;
    bit legal = (blk < 16) && (w < 2);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    if (legal) begin
      m_img[blk*2+w] = d;
      for (int k = 0; k < 4; k++)
        if (w == 0) m_en[blk*4+k] = m_en[blk*4+k] | d[8*k +: 8];
        else        m_en[blk*4+k] = m_en[blk*4+k] & ~d[8*k +: 8];
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " err pulse"}, {63'h0, err}, {63'h0, !legal});
    @(negedge clk);
    chk({tag, " err one cycle"}, {63'h0, err}, 64'h0);
  endtask

  task automatic set_irq(int n, logic v);
    @(negedge clk);
    irq[n] = v;
    m_pend[n >> 3][n & 7] = v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin m_pend[g] = '0; m_en[g] = '0; end
    for (int i = 0; i < 32; i++) m_img[i] = (i >= 24 && i <= 27) ? 32'h0101_0101 : '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R8 outputs low", {gout, 1'b0} | {63'h0, err}, 64'h0);
    rd(9'h0C0, "R8"); rd(9'h0C4, "R8"); rd(9'h0D0, "R8"); rd(9'h0D4, "R8");
    rd(9'h000, "R8");

    set_irq(0, 1'b1); set_irq(9, 1'b1); set_irq(100, 1'b1); set_irq(511, 1'b1);
    rd(9'h008, "R1 R5 raw");
    rd(9'h0C8, "R1 group 48-51 raw");
    rd(9'h00C, "R5 masked none");
    chk("R2 no enables", gout, '0);

    wr(9'h000, 32'h0000_00FF, "R3 set g0");
    chk("R2 R3 g0 out", gout, m_out());
    rd(9'h00C, "R5 masked g0");
    rd(9'h100, "R6 low summary");

    wr(9'h0F0, 32'h8000_0000, "R3 set g63");
    chk("R2 g63 out", gout, m_out());
    rd(9'h104, "R6 high summary");
    rd(9'h108, "R6 unused summary");

    wr(9'h004, 32'h0000_0001, "R4 clr g0 bit0");
    chk("R4 g0 dropped", {63'h0, gout[0]}, 64'h0);
    rd(9'h000, "R7 set image kept");
    rd(9'h004, "R7 clr image");
    set_irq(1, 1'b1);
    chk("R4 other bits kept", {63'h0, gout[0]}, 64'h1);
    rd(9'h00C, "R5 R4 masked");

    wr(9'h0C0, 32'h0000_0010, "R3 R7 preset word");
    rd(9'h0C0, "R7 preset overwritten");
    chk("R2 g48 out", gout, m_out());

    wr(9'h008, 32'hFFFF_FFFF, "R9 raw word");
    wr(9'h00C, 32'hFFFF_FFFF, "R9 masked word");
    wr(9'h100, 32'hFFFF_FFFF, "R9 summary");
    wr(9'h1F0, 32'hFFFF_FFFF, "R9 high addr");
    chk("R9 outputs unchanged", gout, m_out());
    rd(9'h008, "R9 raw unchanged");
    rd(9'h0F4, "R9 image unchanged");

    @(negedge clk); addr = 9'h0F8;
    @(negedge clk);
    chk("R10 ext g63 silent", {63'h0, ext_gout[63]}, 64'h0);
    chk("R10 ext raw g60-63", {32'h0, ext_rdata}, 64'h0);
    chk("R10 ext g0 live", {63'h0, ext_gout[0]}, {63'h0, gout[0]});

    // R11: address change shows up only after the next edge
    @(negedge clk); addr = 9'h0C0;
    #1 chk("R11 before edge", {32'h0, rdata}, {32'h0, m_read(9'h0F8)});
    @(negedge clk);
    chk("R11 after edge", {32'h0, rdata}, {32'h0, m_read(9'h0C0)});

    set_irq(511, 1'b0);
    chk("R1 R2 g63 falls", gout, m_out());
    rd(9'h104, "R6 high summary cleared");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule